// File: doc/BRIEF.md
# Dual-Thread Capture Start Sequencer

This block is the control machine of a parallel-port capture front end that writes into two producer threads. After reset it sits idle and responds to nothing but a one-cycle software trigger. Once triggered, it makes sure that both producer threads can accept data. It first waits, in one state, for thread 0 to report an empty buffer. It then waits, in a second state, for thread 1 to do the same. The two flags are never tested together.

When both threads are ready, the machine waits for a line-end strobe from the sensor side. It then streams exactly one line into the active thread, writing only on cycles where line-valid is high. After the line it goes back to the thread-0 check. The active thread alternates from one line to the next. The buffer-wait states move no data; they only hold progress back. The machine goes back to idle only through reset.

Top module: `capture_start_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the machine enters idle: `phase` = 0, `busy` = 0, `wr_en` = 0 and `wr_thread` = 0.
- R2: In idle (`phase` 0), the line-end, line-valid and ready inputs have no effect, and `phase` stays 0 until `sw_trig` is sampled high.
- R3: `sw_trig` sampled high in idle moves `phase` to 1 (thread-0 wait) on the next cycle. `sw_trig` is ignored in every other phase.
- R4: In `phase` 1, the machine moves to `phase` 2 only on an edge where `rdy0` is high. A high `rdy1` alone does not move it.
- R5: In `phase` 2, the machine moves to `phase` 3 (line-end wait) only on an edge where `rdy1` is high. A low `rdy1` holds it in `phase` 2, whatever `rdy0` does, and raises no error.
- R6: `wr_en` is low in phases 0, 1, 2 and 3, whatever `line_valid` does.
- R7: In `phase` 3, a high `line_end` moves the machine to `phase` 4 (streaming) on the next cycle. `line_valid` alone does not move it.
- R8: In `phase` 4, `wr_en` follows `line_valid` in the same cycle, and `wr_thread` names the active thread.
- R9: On the edge that takes the `LINE_WORDS`-th qualified beat of a line, the machine returns to `phase` 1. Beats need not be consecutive.
- R10: The active thread starts at 0 and flips on every completed line.
- R11: `busy` is high exactly when `phase` is not 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sw_trig | input | 1 | Software start trigger |
| rdy0 | input | 1 | Thread 0 has an empty buffer |
| rdy1 | input | 1 | Thread 1 has an empty buffer |
| line_end | input | 1 | Line-end strobe |
| line_valid | input | 1 | Data beat qualifier |
| wr_en | output | 1 | Write strobe to the active thread |
| wr_thread | output | 1 | Active thread index |
| busy | output | 1 | Machine has left idle |
| phase | output | 3 | State code: 0 idle, 1 thread-0 wait, 2 thread-1 wait, 3 line-end wait, 4 streaming |

## Verification
The bench builds the block with `LINE_WORDS` = 3. This puts three complete lines within a few dozen cycles, so thread alternation back to 0 can be observed. A gapped line-valid pattern shows that the beat counter counts only qualified cycles. The last-beat exit into the thread-0 wait is reached on both threads.

// File: rtl/csq_pkg.sv
// Shared definitions for the capture start sequencer.
package csq_pkg;
    // Machine phases; codes are visible on the top-level phase port.
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_WAIT0  = 3'd1,
        PH_WAIT1  = 3'd2,
        PH_EOL    = 3'd3,
        PH_STREAM = 3'd4
    } phase_e;
endpackage

// File: rtl/csq_phase_fsm.sv
// Phase machine: idle -> thread-0 wait -> thread-1 wait -> line-end wait
// -> streaming -> thread-0 wait. Assumes line_done is only raised in streaming.
module csq_phase_fsm
    import csq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   sw_trig,
    input  logic   rdy0,
    input  logic   rdy1,
    input  logic   line_end,
    input  logic   line_done,
    output phase_e phase
);
    phase_e phase_nx;

    // Next-phase selection; each ready flag is tested in its own phase only.
    always_comb begin
        phase_nx = phase;
        unique case (phase)
            PH_IDLE:   if (sw_trig)   phase_nx = PH_WAIT0;
            PH_WAIT0:  if (rdy0)      phase_nx = PH_WAIT1;
            PH_WAIT1:  if (rdy1)      phase_nx = PH_EOL;
            PH_EOL:    if (line_end)  phase_nx = PH_STREAM;
            PH_STREAM: if (line_done) phase_nx = PH_WAIT0;
            default:                  phase_nx = PH_IDLE;
        endcase
    end

    // Phase register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_IDLE;
        else        phase <= phase_nx;
    end
endmodule

// File: rtl/csq_beat_count.sv
// Counts qualified beats in a line; flags the final beat combinationally.
// Assumes beat is only raised while streaming.
module csq_beat_count #(
    parameter int LINE_WORDS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic beat,
    output logic last
);
    localparam int CW = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(LINE_WORDS - 1);

    logic [CW-1:0] cnt;

    // Final beat of the line.
    always_comb last = beat && (cnt == LAST_IDX);

    // Beat counter, cleared at line completion.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (last) cnt <= '0;
        else if (beat) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/csq_thread_sel.sv
// Active-thread register: starts at thread 0 and flips per completed line.
module csq_thread_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic line_done,
    output logic thread
);
    // Toggle on each completed line.
    always_ff @(posedge clk) begin
        if (!rst_n)         thread <= 1'b0;
        else if (line_done) thread <= ~thread;
    end
endmodule

// File: rtl/capture_start_seq.sv
// Top of the capture start sequencer. Waits for a trigger, checks thread
// readiness one thread at a time, then streams one line per line-end event.
// Assumes all inputs are synchronous to clk.
module capture_start_seq
    import csq_pkg::*;
#(
    parameter int LINE_WORDS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sw_trig,
    input  logic       rdy0,
    input  logic       rdy1,
    input  logic       line_end,
    input  logic       line_valid,
    output logic       wr_en,
    output logic       wr_thread,
    output logic       busy,
    output logic [2:0] phase
);
    phase_e ph;
    logic   beat;
    logic   line_done;

    csq_phase_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .sw_trig(sw_trig), .rdy0(rdy0),
        .rdy1(rdy1), .line_end(line_end), .line_done(line_done), .phase(ph)
    );

    csq_beat_count #(.LINE_WORDS(LINE_WORDS)) u_cnt (
        .clk(clk), .rst_n(rst_n), .beat(beat), .last(line_done)
    );

    csq_thread_sel u_thr (
        .clk(clk), .rst_n(rst_n), .line_done(line_done), .thread(wr_thread)
    );

    // Output decode: write only while streaming and qualified.
    always_comb begin
        beat  = (ph == PH_STREAM) && line_valid;
        wr_en = beat;
        busy  = (ph != PH_IDLE);
        phase = ph;
    end
endmodule

// File: rtl/capture_start_seq_chk.sv
// Protocol checker for capture_start_seq, attached through bind.
module capture_start_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sw_trig,
    input logic       rdy0,
    input logic       rdy1,
    input logic       line_end,
    input logic       wr_en,
    input logic       wr_thread,
    input logic       busy,
    input logic [2:0] phase
);
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd0 && !sw_trig) |=> (phase == 3'd0));
    p_trig_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd0 && sw_trig) |=> (phase == 3'd1));
    p_wait0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd1 && !rdy0) |=> (phase == 3'd1));
    p_wait1_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd2 && !rdy1) |=> (phase == 3'd2));
    p_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (phase == 3'd4));
    p_eol_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd3 && line_end) |=> (phase == 3'd4));
    p_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd4) |=> (phase == 3'd4 || phase == 3'd1));
    p_toggle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(phase) == 3'd4 && phase == 3'd1) |-> (wr_thread != $past(wr_thread)));
    p_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy == (phase != 3'd0));
endmodule

bind capture_start_seq capture_start_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sw_trig(sw_trig), .rdy0(rdy0), .rdy1(rdy1),
    .line_end(line_end), .wr_en(wr_en), .wr_thread(wr_thread),
    .busy(busy), .phase(phase)
);

// File: tb/capture_start_seq_bench.sv
`timescale 1ns/1ps
module capture_start_seq_bench;
    localparam int LW = 3;

    logic clk = 1'b0;
    logic rst_n, sw_trig, rdy0, rdy1, line_end, line_valid;
    logic wr_en, wr_thread, busy;
    logic [2:0] phase;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    capture_start_seq #(.LINE_WORDS(LW)) u_capture_start_seq (
        .clk(clk), .rst_n(rst_n), .sw_trig(sw_trig), .rdy0(rdy0), .rdy1(rdy1),
        .line_end(line_end), .line_valid(line_valid), .wr_en(wr_en),
        .wr_thread(wr_thread), .busy(busy), .phase(phase)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic idle_inputs();
        sw_trig = 0; rdy0 = 0; rdy1 = 0; line_end = 0; line_valid = 0;
    endtask

    task automatic t_reset();
        idle_inputs(); rst_n = 0;
        tick(); tick();
        chk("R1 phase", phase, 0); chk("R1 busy", busy, 0);
        chk("R1 wr_en", wr_en, 0); chk("R1 thread", wr_thread, 0);
        rst_n = 1;
    endtask

    task automatic t_idle_ignore();
        line_end = 1; line_valid = 1; rdy0 = 1; rdy1 = 1;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R2 idle hold", phase, 0);
            chk("R6 no write idle", wr_en, 0);
            chk("R11 busy idle", busy, 0);
        end
        idle_inputs();
    endtask

    task automatic t_trigger();
        sw_trig = 1; tick(); sw_trig = 0;
        chk("R3 trig", phase, 1); chk("R11 busy", busy, 1);
    endtask

    task automatic t_wait0();
        rdy1 = 1; line_valid = 1; line_end = 1; sw_trig = 1;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R4 hold wait0", phase, 1);
            chk("R6 no write wait0", wr_en, 0);
        end
        idle_inputs(); rdy0 = 1; tick(); rdy0 = 0;
        chk("R4 advance", phase, 2);
    endtask

    task automatic t_wait1();
        rdy0 = 1; line_valid = 1; line_end = 1;
        for (int i = 0; i < 2; i++) begin
            tick();
            chk("R5 hold wait1", phase, 2);
            chk("R6 no write wait1", wr_en, 0);
        end
        idle_inputs(); rdy1 = 1; tick(); rdy1 = 0;
        chk("R5 advance", phase, 3);
    endtask

    task automatic t_eol();
        line_valid = 1; sw_trig = 1; rdy0 = 1; rdy1 = 1;
        tick();
        chk("R7 hold eol", phase, 3);
        chk("R6 no write eol", wr_en, 0);
        idle_inputs(); line_end = 1; tick(); line_end = 0;
        chk("R7 advance", phase, 4);
    endtask

    task automatic t_stream(input int thr);
        automatic bit pat[5] = '{1, 0, 1, 0, 1};
        for (int i = 0; i < 5; i++) begin
            line_valid = pat[i]; #1;
            chk("R8 wr_en follows valid", wr_en, pat[i]);
            chk("R8 thread", wr_thread, thr);
            tick();
            if (i < 4) chk("R9 still streaming", phase, 4);
        end
        line_valid = 1; #1;
        chk("R9 back to wait0", phase, 1);
        chk("R6 no write after line", wr_en, 0);
        chk("R10 toggle", wr_thread, 1 - thr);
        line_valid = 0;
    endtask

    task automatic t_reach_stream();
        rdy0 = 1; tick(); rdy0 = 0;
        rdy1 = 1; tick(); rdy1 = 0;
        line_end = 1; tick(); line_end = 0;
        chk("R7 reach stream", phase, 4);
    endtask

    initial begin
        t_reset();
        t_idle_ignore();
        t_trigger();
        t_wait0();
        t_wait1();
        t_eol();
        t_stream(0);
        t_reach_stream();
        t_stream(1);
        t_reach_stream();
        t_stream(0);
        t_reset();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule